// File: doc/BRIEF.md
# Receive Frame Status Trailer Appender

This block closes an Ethernet receive path. It passes every received byte through to a byte-wide output stream and meanwhile counts the bytes of the frame, FCS included. It also gathers four per-frame error indications: FIFO overflow, collision, framing error and FCS mismatch. Once the last byte of a frame has gone out, it emits four more bytes that describe the frame. These bytes hold the 12-bit byte count, the four error flags, and two running statistics: the number of runt frames and the number of frames that saw a collision.

Software or a DMA engine that writes frames into receive buffers finds the status directly behind the frame data. The payload length is the reported count minus the four FCS bytes. A receive buffer of 2048 bytes must be large enough for the frame plus its four status bytes. The source must stay idle for four cycles after each frame end, because there is no backpressure.

Top module: `rxst_trailer`

## Requirements
- R1: Each input byte with `in_valid` high appears on `out_data` one cycle later with `out_valid` high and `out_last` low, in arrival order.
- R2: The four status bytes follow the last frame byte on the next four cycles, with no gap. `out_last` is high on the fourth status byte and on no other output byte.
- R3: Status byte 0 is bits [7:0] of the frame byte count. The count covers every valid byte from the `in_sof` byte through the `in_eof` byte, FCS included.
- R4: Status byte 1 carries the flags in its upper nibble: overflow in bit 7, collision in bit 6, framing error in bit 5 and FCS error in bit 4. Its bits [3:0] carry count bits [11:8].
- R5: An error strobe counts only in a cycle with `in_valid` high. This includes the start and end bytes. Once seen, a flag stays set until the frame ends. Each new start byte clears all flags.
- R6: The byte count saturates at 4095 instead of wrapping. Byte 0 is then 0xFF and the low nibble of byte 1 is 0xF.
- R7: Status byte 2 is an 8-bit runt counter. It starts at 0 after reset and rises by one for each frame whose count is below 64. The byte shows the value after the current frame has been counted, and the counter wraps from 255 to 0.
- R8: Status byte 3 is an 8-bit collision counter. It starts at 0 after reset and rises by one for each frame with the collision flag set. The byte shows the value after the current frame has been counted, and the counter wraps from 255 to 0.
- R9: During and right after reset, `out_valid` and `out_last` are low.
- R10: The source keeps `in_valid` low for the four cycles after an `in_eof` byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Marks the first byte of a frame |
| in_eof | input | 1 | Marks the last byte of a frame |
| err_ovf | input | 1 | FIFO overflow strobe |
| err_col | input | 1 | Collision strobe |
| err_fram | input | 1 | Framing error strobe |
| err_fcs | input | 1 | FCS mismatch strobe |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Frame byte or status byte |
| out_last | output | 1 | Marks the final status byte |

## Verification
The bench builds the block with its default parameters: a 12-bit count, 8-bit statistics and a runt limit of 64. With these values, a 4100-byte frame is enough to reach count saturation. A few hundred short frames that each carry a collision drive both statistics counters through their wrap from 255 to 0. Placing error strobes on the start byte, on the end byte and outside any frame exercises the edges of the sticky flags.

// File: rtl/rxst_pkg.sv
package rxst_pkg;

    localparam int BYTE_W = 8;
    localparam int FIELD_CNT_W = 12;

    typedef enum logic [2:0] {
        PH_DATA = 3'd0,
        PH_ST0  = 3'd1,
        PH_ST1  = 3'd2,
        PH_ST2  = 3'd3,
        PH_ST3  = 3'd4
    } phase_e;

    typedef struct packed {
        logic ovf;
        logic col;
        logic fram;
        logic fcs;
    } rx_flags_t;

endpackage

// File: rtl/rxst_count.sv
module rxst_count
    import rxst_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eof,
    input  rx_flags_t        strobes,
    output logic [CNT_W-1:0] cnt_q,
    output rx_flags_t        flg_q,
    output logic             done_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        rx_flags_t        flg;
        logic             done;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [CNT_W-1:0] base_cnt;
    rx_flags_t        base_flg;

    always_comb begin
        st_d      = st_q;
        st_d.done = in_valid & in_eof;
        base_cnt  = in_sof ? '0 : st_q.cnt;
        base_flg  = in_sof ? '0 : st_q.flg;
        if (in_valid) begin
            st_d.cnt = (base_cnt == CNT_MAX) ? CNT_MAX : base_cnt + 1'b1;
            st_d.flg = base_flg | strobes;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_q  = st_q.cnt;
    assign flg_q  = st_q.flg;
    assign done_q = st_q.done;

    a_r6_count_never_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_sof) |=> (cnt_q >= $past(cnt_q)));

    a_r5_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_sof) |=> ((flg_q & $past(flg_q)) == $past(flg_q)));

    a_r5_idle_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(flg_q) && $stable(cnt_q)));

endmodule

// File: rtl/rxst_stats.sv
module rxst_stats #(
    parameter int CNT_W    = 12,
    parameter int STAT_W   = 8,
    parameter int RUNT_MIN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              col,
    output logic [STAT_W-1:0] runt_q,
    output logic [STAT_W-1:0] coll_q
);
    localparam logic [CNT_W-1:0] RUNT_LIM = CNT_W'(RUNT_MIN);

    typedef struct packed {
        logic [STAT_W-1:0] runt;
        logic [STAT_W-1:0] coll;
    } stat_st_t;

    stat_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (done) begin
            if (cnt < RUNT_LIM) st_d.runt = st_q.runt + 1'b1;
            if (col)            st_d.coll = st_q.coll + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign runt_q = st_q.runt;
    assign coll_q = st_q.coll;

    a_r7_runt_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (runt_q == $past(runt_q)) || (runt_q == STAT_W'($past(runt_q) + 1'b1)));

    a_r8_coll_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(coll_q));

endmodule

// File: rtl/rxst_emit.sv
module rxst_emit
    import rxst_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_eof,
    input  logic [CNT_W-1:0]  cnt,
    input  rx_flags_t         flg,
    input  logic [STAT_W-1:0] runt,
    input  logic [STAT_W-1:0] coll,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic              out_last,
    output logic              busy
);
    typedef struct packed {
        phase_e     phase;
        logic       valid;
        logic [7:0] data;
        logic       last;
    } emit_st_t;

    emit_st_t st_d, st_q;
    logic [FIELD_CNT_W-1:0] cnt_field;

    assign cnt_field = FIELD_CNT_W'(cnt);

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.last  = 1'b0;
        unique case (st_q.phase)
            PH_DATA: begin
                if (in_valid) begin
                    st_d.valid = 1'b1;
                    st_d.data  = in_data;
                    if (in_eof) st_d.phase = PH_ST0;
                end
            end
            PH_ST0: begin
                st_d.valid = 1'b1;
                st_d.data  = cnt_field[7:0];
                st_d.phase = PH_ST1;
            end
            PH_ST1: begin
                st_d.valid = 1'b1;
                st_d.data  = {flg, cnt_field[11:8]};
                st_d.phase = PH_ST2;
            end
            PH_ST2: begin
                st_d.valid = 1'b1;
                st_d.data  = 8'(runt);
                st_d.phase = PH_ST3;
            end
            PH_ST3: begin
                st_d.valid = 1'b1;
                st_d.last  = 1'b1;
                st_d.data  = 8'(coll);
                st_d.phase = PH_DATA;
            end
            default: st_d.phase = PH_DATA;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: PH_DATA, valid: 1'b0, data: 8'h00, last: 1'b0};
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_data  = st_q.data;
    assign out_last  = st_q.last;
    assign busy      = (st_q.phase != PH_DATA);

    a_r10_source_idle_in_trailer: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !in_valid);

    a_r2_last_only_after_final_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_last) |-> ($past(st_q.phase) == PH_ST3));

    a_r2_no_gap_before_trailer: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> out_valid);

    a_r1_data_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !busy) |=> (out_valid && !out_last && out_data == $past(in_data)));

endmodule

// File: rtl/rxst_trailer.sv
module rxst_trailer
    import rxst_pkg::*;
#(
    parameter int CNT_W    = 12,
    parameter int STAT_W   = 8,
    parameter int RUNT_MIN = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_sof,
    input  logic       in_eof,
    input  logic       err_ovf,
    input  logic       err_col,
    input  logic       err_fram,
    input  logic       err_fcs,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_last
);
    rx_flags_t         strobes;
    rx_flags_t         flg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              done_q;
    logic [STAT_W-1:0] runt_q;
    logic [STAT_W-1:0] coll_q;
    logic              busy;

    assign strobes = '{ovf: err_ovf, col: err_col, fram: err_fram, fcs: err_fcs};

    rxst_count #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .in_eof   (in_eof),
        .strobes  (strobes),
        .cnt_q    (cnt_q),
        .flg_q    (flg_q),
        .done_q   (done_q)
    );

    rxst_stats #(.CNT_W(CNT_W), .STAT_W(STAT_W), .RUNT_MIN(RUNT_MIN)) u_stats (
        .clk    (clk),
        .rst_n  (rst_n),
        .done   (done_q),
        .cnt    (cnt_q),
        .col    (flg_q.col),
        .runt_q (runt_q),
        .coll_q (coll_q)
    );

    rxst_emit #(.CNT_W(CNT_W), .STAT_W(STAT_W)) u_emit (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_eof    (in_eof),
        .cnt       (cnt_q),
        .flg       (flg_q),
        .runt      (runt_q),
        .coll      (coll_q),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last),
        .busy      (busy)
    );

    a_r9_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_last));

endmodule

// File: tb/rxst_trailer_test.sv
module rxst_trailer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_sof = 1'b0, in_eof = 1'b0;
    logic       err_ovf = 1'b0, err_col = 1'b0, err_fram = 1'b0, err_fcs = 1'b0;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_last;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_runt = 8'd0;
    logic [7:0] exp_coll = 8'd0;
    logic [7:0] g_b0, g_b1, g_b2, g_b3;
    logic [7:0] cap_d[$];
    bit         cap_l[$];

    always #4 clk = ~clk;

    rxst_trailer uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof), .err_ovf(err_ovf), .err_col(err_col),
        .err_fram(err_fram), .err_fcs(err_fcs), .out_valid(out_valid),
        .out_data(out_data), .out_last(out_last)
    );

    always @(negedge clk) begin
        if (out_valid) begin
            cap_d.push_back(out_data);
            cap_l.push_back(out_last);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_frame(input int len, input int ovf_at, input int col_at,
                             input int fram_at, input int fcs_at, input logic [7:0] seed);
        int cnt;
        int bad;
        int last_pos;
        logic [7:0] b1;
        cap_d.delete();
        cap_l.delete();
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = 8'(seed + i);
            in_sof   = (i == 0);
            in_eof   = (i == len - 1);
            err_ovf  = (i == ovf_at);
            err_col  = (i == col_at);
            err_fram = (i == fram_at);
            err_fcs  = (i == fcs_at);
        end
        @(negedge clk);
        {in_valid, in_sof, in_eof, err_ovf, err_col, err_fram, err_fcs} = '0;
        repeat (5) @(negedge clk);
        cnt = (len > 4095) ? 4095 : len;
        if (cnt < 64) exp_runt = exp_runt + 8'd1;
        if (col_at >= 0) exp_coll = exp_coll + 8'd1;
        b1 = {(ovf_at >= 0), (col_at >= 0), (fram_at >= 0), (fcs_at >= 0), 4'(cnt >> 8)};
        check(cap_d.size() == len + 4, "R2 output length", cap_d.size(), len + 4);
        if (cap_d.size() == len + 4) begin
            bad = 0;
            last_pos = -1;
            for (int i = 0; i < len; i++)
                if (cap_d[i] != 8'(seed + i)) bad++;
            for (int i = 0; i < len + 4; i++)
                if (cap_l[i]) last_pos = (last_pos == -1) ? i : -2;
            check(bad == 0, "R1 data bytes mismatched", bad, 0);
            check(last_pos == len + 3, "R2 last position", last_pos, len + 3);
            g_b0 = cap_d[len];
            g_b1 = cap_d[len + 1];
            g_b2 = cap_d[len + 2];
            g_b3 = cap_d[len + 3];
            check(g_b0 == 8'(cnt), "R3 byte0 count low", g_b0, 8'(cnt));
            check(g_b1 == b1, "R4 byte1 flags and count high", g_b1, b1);
            check(g_b2 == exp_runt, "R7 byte2 runt count", g_b2, exp_runt);
            check(g_b3 == exp_coll, "R8 byte3 collision count", g_b3, exp_coll);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R9 valid in reset", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && out_last == 1'b0, "R9 quiet after reset",
              {out_valid, out_last}, 0);
    endtask

    task automatic t_plain();
        run_frame(70, -1, -1, -1, -1, 8'h10);
        run_frame(64, -1, -1, -1, -1, 8'hA0);
    endtask

    task automatic t_sticky();
        run_frame(100, 0, 40, -1, 99, 8'h33);
        check(g_b1[7:4] == 4'b1101, "R5 flags from sof and eof bytes", g_b1[7:4], 4'b1101);
        @(negedge clk);
        err_fram = 1'b1;
        @(negedge clk);
        err_fram = 1'b0;
        run_frame(80, -1, -1, -1, -1, 8'h55);
        check(g_b1[7:4] == 4'b0000, "R5 flags cleared and idle strobe ignored",
              g_b1[7:4], 0);
        run_frame(90, -1, -1, 89, -1, 8'h02);
        check(g_b1[7:4] == 4'b0010, "R5 framing flag on eof byte", g_b1[7:4], 4'b0010);
    endtask

    task automatic t_lengths();
        run_frame(300, -1, -1, -1, -1, 8'h07);
        run_frame(4100, -1, -1, -1, -1, 8'hC3);
        check(g_b0 == 8'hFF && g_b1[3:0] == 4'hF, "R6 count saturates",
              {g_b1[3:0], g_b0}, 4095);
        run_frame(1, -1, -1, -1, -1, 8'h99);
        run_frame(63, -1, -1, -1, -1, 8'h01);
    endtask

    task automatic t_wrap();
        for (int k = 0; k < 256; k++)
            run_frame(2, -1, 1, -1, -1, 8'(k));
        check(g_b2 == exp_runt, "R7 runt wraps", g_b2, exp_runt);
        check(g_b3 == exp_coll, "R8 collision wraps", g_b3, exp_coll);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_plain();
        t_sticky();
        t_lengths();
        t_wrap();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule